// File: doc/BRIEF.md
# Program Counter and Branch Unit

This block keeps the 12-bit fetch address of a small sequencer and works out, every clock, where the next fetch goes. It takes the 16-bit instruction word at the current address, the zero and carry flags, a 4-bit operand read from the register file, and a flag telling whether input port 0 holds a nonzero value. From these it chooses one of several paths:
- a step to the following word;
- an absolute jump;
- a subroutine call or return, using a small return stack;
- a flag-tested jump into the upper address window;
- a forward skip when a register bit is set or a register equals a small constant;
- a jump forward by a register value;
- a stall that waits for an event.

The register file sits outside the block. The block drives the register address from the current instruction word, and the register file returns the 4-bit value in the same cycle. One instruction is retired on every clock, and the registered address is the one used for the next fetch.

Top module: `seq_pc_unit`

## Requirements
- R1: Reset sets the fetch address to 0x000 and empties the return stack, so a return executed after reset gives 0x000 even if calls were made before the reset.
- R2: A word whose top nibble is 0xC loads bits 11:0 into the fetch address.
- R3: A word whose top nibble is 0xA loads bits 11:0 into the fetch address and pushes the address after the current one. The word 0xB000 pops the stack into the fetch address.
- R4: A return on an empty stack gives address 0x000.
- R5: The stack holds four return addresses. A fifth push drops the oldest entry, so four returns give the latest four addresses, newest first, and a fifth return gives 0x000.
- R6: A word with top nibble 0xD is a conditional jump. Bits 11:10 choose the condition: 00 = Z set, 01 = Z clear, 10 = C set, 11 = C clear. When taken, the address becomes bits 9:0 plus 0xC00. When not taken, it becomes the current address plus 1.
- R7: A word with top nibble 0xE tests bit number (bits 11:10) of the register operand. When that bit is 1, the address becomes the current address plus the unsigned offset in bits 4:0, modulo 4096. Otherwise it becomes the current address plus 1.
- R8: A word with top nibble 0xF compares the register operand with the 2-bit constant in bits 11:10, zero-extended. When they are equal, the address becomes the current address plus the offset in bits 4:0. Otherwise it becomes the current address plus 1.
- R9: A word whose bits 15:10 are 101110 adds the 4-bit register operand to the current address, modulo 4096.
- R10: A word whose bits 15:10 are 101111 advances the address by 1 when the event input is high, and holds the address unchanged when it is low.
- R11: Every other word, including other words in the 0xB range, advances the address by 1, wrapping from 0xFFF to 0x000.
- R12: The register address output always equals bits 9:5 of the current instruction word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 16 | Instruction word at the current fetch address |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| reg_val | input | 4 | Register file value at reg_sel |
| evt_nz | input | 1 | High when input port 0 is nonzero |
| reg_sel | output | 5 | Register address taken from the instruction |
| pc | output | 12 | Fetch address for the next instruction |

## Verification
The only functions that can act in the same cycle are address arithmetic and the register read. A skip tests a register value that is chosen by the same word that supplies the offset, so both must line up within one clock. The bench sends skips whose register address, bit index and offset all differ. It then checks the new address together with reg_sel against values worked out from the word. Offsets near the top of the address space are also sent, to check that wrapping and the skip decision are correct in the same step.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam int INSTR_W = 16;
    localparam int ADDR_W  = 12;
    localparam int WIN_W   = 10;
    localparam int OFF_W   = 5;
    localparam int RSEL_W  = 5;
    localparam int RVAL_W  = 4;

    typedef enum logic [3:0] {
        OP_STEP,
        OP_JMP,
        OP_CALL,
        OP_RET,
        OP_COND,
        OP_BITSKIP,
        OP_EQSKIP,
        OP_IND,
        OP_WAIT
    } op_kind_e;

    typedef struct packed {
        op_kind_e            kind;
        logic [ADDR_W-1:0]   abs_tgt;
        logic [WIN_W-1:0]    win_addr;
        logic [1:0]          sel2;
        logic [OFF_W-1:0]    offset;
        logic [RSEL_W-1:0]   reg_addr;
    } dec_s;

endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
    import pcu_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_s               dec
);

    localparam logic [INSTR_W-1:0] RET_WORD = 16'hB000;

    always_comb begin
        dec          = '0;
        dec.abs_tgt  = instr[ADDR_W-1:0];
        dec.win_addr = instr[WIN_W-1:0];
        dec.sel2     = instr[11:10];
        dec.offset   = instr[OFF_W-1:0];
        dec.reg_addr = instr[9:5];
        case (instr[15:12])
            4'hC:    dec.kind = OP_JMP;
            4'hA:    dec.kind = OP_CALL;
            4'hD:    dec.kind = OP_COND;
            4'hE:    dec.kind = OP_BITSKIP;
            4'hF:    dec.kind = OP_EQSKIP;
            4'hB: begin
                if (instr == RET_WORD)          dec.kind = OP_RET;
                else if (instr[11:10] == 2'b10) dec.kind = OP_IND;
                else if (instr[11:10] == 2'b11) dec.kind = OP_WAIT;
                else                            dec.kind = OP_STEP;
            end
            default: dec.kind = OP_STEP;
        endcase
    end

endmodule

// File: rtl/pcu_next.sv
module pcu_next
    import pcu_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_BASE = 12'hC00
)(
    input  dec_s               dec,
    input  logic [ADDR_W-1:0]  pc_cur,
    input  logic               flag_z,
    input  logic               flag_c,
    input  logic [RVAL_W-1:0]  reg_val,
    input  logic               evt_nz,
    input  logic [ADDR_W-1:0]  ret_addr,
    output logic [ADDR_W-1:0]  pc_nxt,
    output logic [ADDR_W-1:0]  push_addr,
    output logic               push,
    output logic               pop
);

    logic [ADDR_W-1:0] pc_inc;
    logic [ADDR_W-1:0] pc_skip;
    logic [ADDR_W-1:0] pc_ind;
    logic [ADDR_W-1:0] pc_win;
    logic              cond_ok;
    logic              bit_ok;
    logic              eq_ok;

    always_comb begin
        pc_inc  = pc_cur + ADDR_W'(1);
        pc_skip = pc_cur + ADDR_W'(dec.offset);
        pc_ind  = pc_cur + ADDR_W'(reg_val);
        pc_win  = ADDR_W'(dec.win_addr) + WIN_BASE;
        case (dec.sel2)
            2'b00:   cond_ok = flag_z;
            2'b01:   cond_ok = !flag_z;
            2'b10:   cond_ok = flag_c;
            default: cond_ok = !flag_c;
        endcase
        bit_ok = reg_val[dec.sel2];
        eq_ok  = (reg_val == RVAL_W'(dec.sel2));

        pc_nxt    = pc_inc;
        push_addr = pc_inc;
        push      = 1'b0;
        pop       = 1'b0;
        case (dec.kind)
            OP_JMP:     pc_nxt = dec.abs_tgt;
            OP_CALL: begin
                pc_nxt = dec.abs_tgt;
                push   = 1'b1;
            end
            OP_RET: begin
                pc_nxt = ret_addr;
                pop    = 1'b1;
            end
            OP_COND:    if (cond_ok) pc_nxt = pc_win;
            OP_BITSKIP: if (bit_ok)  pc_nxt = pc_skip;
            OP_EQSKIP:  if (eq_ok)   pc_nxt = pc_skip;
            OP_IND:     pc_nxt = pc_ind;
            OP_WAIT:    if (!evt_nz) pc_nxt = pc_cur;
            default:    pc_nxt = pc_inc;
        endcase
    end

endmodule

// File: rtl/pcu_ret_stack.sv
module pcu_ret_stack #(
    parameter int DEPTH = 4,
    parameter int W     = 12
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_addr,
    output logic [W-1:0] top_addr
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] slot;
        logic [PTR_W-1:0]        wr_ptr;
        logic [CNT_W-1:0]        used;
    } stk_s;

    stk_s stk_d, stk_q;
    logic [PTR_W-1:0] top_idx;

    always_comb begin
        top_idx  = (stk_q.wr_ptr == '0) ? PTR_LAST : stk_q.wr_ptr - PTR_W'(1);
        top_addr = (stk_q.used == '0) ? '0 : stk_q.slot[top_idx];

        stk_d = stk_q;
        if (push) begin
            stk_d.slot[stk_q.wr_ptr] = push_addr;
            stk_d.wr_ptr = (stk_q.wr_ptr == PTR_LAST) ? '0 : stk_q.wr_ptr + PTR_W'(1);
            if (stk_q.used != CNT_FULL) stk_d.used = stk_q.used + CNT_W'(1);
        end else if (pop && stk_q.used != '0) begin
            stk_d.wr_ptr = top_idx;
            stk_d.used   = stk_q.used - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end

endmodule

// File: rtl/seq_pc_unit.sv
module seq_pc_unit
    import pcu_pkg::*;
#(
    parameter int                STACK_DEPTH = 4,
    parameter logic [ADDR_W-1:0] WIN_BASE    = 12'hC00
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr,
    input  logic               flag_z,
    input  logic               flag_c,
    input  logic [RVAL_W-1:0]  reg_val,
    input  logic               evt_nz,
    output logic [RSEL_W-1:0]  reg_sel,
    output logic [ADDR_W-1:0]  pc
);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } pc_s;

    pc_s  st_d, st_q;
    dec_s dec;
    logic [ADDR_W-1:0] pc_nxt;
    logic [ADDR_W-1:0] push_addr;
    logic [ADDR_W-1:0] ret_addr;
    logic              push;
    logic              pop;

    pcu_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    pcu_next #(.WIN_BASE(WIN_BASE)) u_next (
        .dec       (dec),
        .pc_cur    (st_q.pc),
        .flag_z    (flag_z),
        .flag_c    (flag_c),
        .reg_val   (reg_val),
        .evt_nz    (evt_nz),
        .ret_addr  (ret_addr),
        .pc_nxt    (pc_nxt),
        .push_addr (push_addr),
        .push      (push),
        .pop       (pop)
    );

    pcu_ret_stack #(.DEPTH(STACK_DEPTH), .W(ADDR_W)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .push_addr (push_addr),
        .top_addr  (ret_addr)
    );

    always_comb begin
        st_d    = st_q;
        st_d.pc = pc_nxt;
        reg_sel = dec.reg_addr;
        pc      = st_q.pc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pcu_checker.sv
module pcu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] instr,
    input logic        evt_nz,
    input logic [11:0] pc
);

    p_jmp_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[15:12] == 4'hC) |=> (pc == $past(instr[11:0])));

    p_call_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[15:12] == 4'hA) |=> (pc == $past(instr[11:0])));

    p_cond_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[15:12] == 4'hD) |=> ((pc == $past(pc) + 12'd1) || (pc >= 12'hC00)));

    p_wait_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[15:10] == 6'b101111 && !evt_nz) |=> $stable(pc));

    p_wait_go_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[15:10] == 6'b101111 && evt_nz) |=> (pc == $past(pc) + 12'd1));

    p_plain_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[15] == 1'b0) |=> (pc == $past(pc) + 12'd1));

endmodule

bind seq_pc_unit pcu_checker u_pcu_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .instr  (instr),
    .evt_nz (evt_nz),
    .pc     (pc)
);

// File: tb/test_seq_pc_unit.sv
`timescale 1ns/1ps
module test_seq_pc_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = 16'h0000;
    logic        flag_z = 1'b0;
    logic        flag_c = 1'b0;
    logic [3:0]  reg_val = 4'h0;
    logic        evt_nz = 1'b0;
    logic [4:0]  reg_sel;
    logic [11:0] pc;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    seq_pc_unit i_seq_pc_unit (
        .clk     (clk),
        .rst_n   (rst_n),
        .instr   (instr),
        .flag_z  (flag_z),
        .flag_c  (flag_c),
        .reg_val (reg_val),
        .evt_nz  (evt_nz),
        .reg_sel (reg_sel),
        .pc      (pc)
    );

    // {req, start pc, word, z, c, reg value, event, expected pc}
    localparam int NV = 20;
    localparam logic [50:0] VEC [NV] = '{
        {4'd11, 12'h100, 16'h0123, 1'b0, 1'b0, 4'h0, 1'b0, 12'h101}, // R11
        {4'd11, 12'hFFF, 16'h8800, 1'b0, 1'b0, 4'h0, 1'b0, 12'h000}, // R11 wrap
        {4'd11, 12'h2A0, 16'hB400, 1'b1, 1'b1, 4'hF, 1'b1, 12'h2A1}, // R11 other 0xB word
        {4'd6,  12'h200, 16'hD055, 1'b1, 1'b0, 4'h0, 1'b0, 12'hC55}, // R6 Z set taken
        {4'd6,  12'h200, 16'hD055, 1'b0, 1'b1, 4'h0, 1'b0, 12'h201}, // R6 Z set not taken
        {4'd6,  12'h210, 16'hD7FF, 1'b0, 1'b0, 4'h0, 1'b0, 12'hFFF}, // R6 Z clear taken
        {4'd6,  12'h220, 16'hD810, 1'b0, 1'b1, 4'h0, 1'b0, 12'hC10}, // R6 C set taken
        {4'd6,  12'h230, 16'hDC10, 1'b0, 1'b1, 4'h0, 1'b0, 12'h231}, // R6 C clear not taken
        {4'd6,  12'h240, 16'hDC00, 1'b1, 1'b0, 4'h0, 1'b0, 12'hC00}, // R6 C clear taken
        {4'd7,  12'h300, 16'hE867, 1'b0, 1'b0, 4'b0100, 1'b0, 12'h307}, // R7 bit set
        {4'd7,  12'h300, 16'hE867, 1'b0, 1'b0, 4'b1011, 1'b0, 12'h301}, // R7 bit clear
        {4'd7,  12'hFFE, 16'hE00F, 1'b0, 1'b0, 4'b0001, 1'b0, 12'h00D}, // R7 wrap
        {4'd7,  12'h310, 16'hEFFF, 1'b0, 1'b0, 4'b1000, 1'b0, 12'h32F}, // R7 bit 3
        {4'd8,  12'h400, 16'hFC1F, 1'b0, 1'b0, 4'h3, 1'b0, 12'h41F}, // R8 equal
        {4'd8,  12'h400, 16'hFC1F, 1'b0, 1'b0, 4'h7, 1'b0, 12'h401}, // R8 upper bit differs
        {4'd9,  12'h500, 16'hB800, 1'b0, 1'b0, 4'h9, 1'b0, 12'h509}, // R9
        {4'd9,  12'hFFA, 16'hBBE0, 1'b0, 1'b0, 4'hF, 1'b0, 12'h009}, // R9 wrap
        {4'd10, 12'h600, 16'hBC00, 1'b0, 1'b0, 4'h0, 1'b0, 12'h600}, // R10 hold
        {4'd10, 12'h600, 16'hBC00, 1'b0, 1'b0, 4'h0, 1'b1, 12'h601}, // R10 go
        {4'd2,  12'h000, 16'hCABC, 1'b0, 1'b0, 4'h0, 1'b0, 12'hABC}  // R2
    };

    task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%03h expected=%03h", tag, act, exp);
        end
    endtask

    // drive one word at the falling edge, sample after the next rising edge
    task automatic exec(input logic [15:0] w, input logic z, input logic c,
                        input logic [3:0] rv, input logic ev);
        @(negedge clk);
        instr = w; flag_z = z; flag_c = c; reg_val = rv; evt_nz = ev;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset pc", pc, 12'h000);
        @(negedge clk);
        rst_n = 1'b1;
        // R4: return on empty stack
        exec(16'hB000, 1'b0, 1'b0, 4'h0, 1'b0);
        chk("R4 empty return", pc, 12'h000);

        for (int i = 0; i < NV; i++) begin
            logic [50:0] v;
            string tg;
            v = VEC[i];
            exec({4'hC, v[46:35]}, 1'b0, 1'b0, 4'h0, 1'b0);
            exec(v[34:19], v[18], v[17], v[16:13], v[12]);
            tg = $sformatf("R%0d vector %0d", v[50:47], i);
            chk(tg, pc, v[11:0]);
        end

        // R12: register address follows bits 9:5
        @(negedge clk);
        instr = 16'hE867;
        #1;
        chk("R12 reg_sel", 12'(reg_sel), 12'h003);
        instr = 16'hFBE0;
        #1;
        chk("R12 reg_sel", 12'(reg_sel), 12'h01F);

        // R3: call then return
        exec(16'hC010, 1'b0, 1'b0, 4'h0, 1'b0);
        exec(16'hA800, 1'b0, 1'b0, 4'h0, 1'b0);
        chk("R3 call target", pc, 12'h800);
        exec(16'hB000, 1'b0, 1'b0, 4'h0, 1'b0);
        chk("R3 return", pc, 12'h011);

        // R5: five nested calls, then five returns
        exec(16'hC020, 1'b0, 1'b0, 4'h0, 1'b0);
        for (int k = 1; k <= 5; k++) begin
            exec({4'hA, 4'(k), 8'h00}, 1'b0, 1'b0, 4'h0, 1'b0);
        end
        chk("R5 deepest call", pc, 12'h500);
        exec(16'hB000, 1'b0, 1'b0, 4'h0, 1'b0);
        chk("R5 return 1", pc, 12'h401);
        exec(16'hB000, 1'b0, 1'b0, 4'h0, 1'b0);
        chk("R5 return 2", pc, 12'h301);
        exec(16'hB000, 1'b0, 1'b0, 4'h0, 1'b0);
        chk("R5 return 3", pc, 12'h201);
        exec(16'hB000, 1'b0, 1'b0, 4'h0, 1'b0);
        chk("R5 return 4", pc, 12'h101);
        exec(16'hB000, 1'b0, 1'b0, 4'h0, 1'b0);
        chk("R5 oldest dropped", pc, 12'h000);

        // R1: reset clears the stack
        exec(16'hC050, 1'b0, 1'b0, 4'h0, 1'b0);
        exec(16'hA123, 1'b0, 1'b0, 4'h0, 1'b0);
        @(negedge clk);
        instr = 16'h0000;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 reset mid-run pc", pc, 12'h000);
        @(negedge clk);
        rst_n = 1'b1;
        exec(16'hB000, 1'b0, 1'b0, 4'h0, 1'b0);
        chk("R1 stack cleared", pc, 12'h000);

        finish_run();
    end

endmodule